// File: doc/BRIEF.md
# Fault Interrupt Hub

The fault interrupt hub gathers a one-bit internal-fault line from each of up to eight neighbouring cores and folds them onto a single interrupt pin toward the host processor. Each core keeps its own detailed status register; this hub only answers the first question software asks when the pin fires: which core or cores are in trouble. Software reads the hub, learns the offending source index, then turns to that core's own status register for the precise cause. Only a core's internal fault conditions are wired here; register-access misuse is reported by each core inside its own status word and never reaches this hub.

Each fault line passes through a configurable synchronizer and is then turned into a sticky pending bit on its rising edge, so a fault pulse as short as one clock is held until software acknowledges it. A per-source enable register decides which pending bits may drive the interrupt pin, and a third read-only view shows exactly those pending bits that are also enabled, which is the set that raised the pin. Acknowledgement is done by writing ones to the pending register.

Top module: `fault_irq_hub`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, the pending register, the enable register and `irq_out` all read zero.
- R2: A 0-to-1 transition on `fault_in[i]` sets pending bit i; reading `bus_addr` = 0 returns the pending register, and the bit stays set until software clears it.
- R3: Pending bits are set by edges, not levels: a fault line held high sets its bit once, and after it is cleared the bit stays clear until the line falls and rises again.
- R4: A write to `bus_addr` = 0 clears every pending bit whose `bus_wdata` bit is 1 and leaves bits written with 0 untouched.
- R5: When a clearing write and a new rising edge hit the same bit in the same cycle, the bit ends up set.
- R6: `bus_addr` = 1 is the per-source enable register: a write stores `bus_wdata`, a read returns the stored value.
- R7: `irq_out` is a register output equal to the OR over all sources of (pending AND enable), updated on the same clock edge that updates the pending and enable registers.
- R8: Reading `bus_addr` = 2 returns pending AND enable (the sources that raised the interrupt); `bus_addr` = 3 reads zero; writes to addresses 2 and 3 change no state.
- R9: A fault transition that is stable before clock edge k sets its pending bit at edge k + SYNC_STAGES (SYNC_STAGES synchronizer flops, default 2, plus the capture flop), and not earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fault_in | input | NUM_SRC | One internal-fault line per connected core |
| bus_wr | input | 1 | Write strobe for the register interface |
| bus_addr | input | 2 | Register select: 0 pending, 1 enable, 2 cause, 3 reserved |
| bus_wdata | input | NUM_SRC | Write data |
| bus_rdata | output | NUM_SRC | Read data for the selected register (combinational from state) |
| irq_out | output | 1 | Registered interrupt toward the host processor |

## Verification
The hub is driven with single-cycle fault pulses, lines held high across an acknowledgement, several sources firing together, and a clearing write landing on the very cycle a new edge arrives; these separate edge capture from level capture and show which of clear and set wins. Enable patterns that cover some, all and none of the pending bits tell apart the raw pending view, the cause view and the interrupt pin. A long stretch of random faults and register writes at every address is compared cycle by cycle against a behavioural model that delays the fault lines by the synchronizer depth, which also pins down the exact capture latency.

// File: rtl/fault_irq_pkg.sv
`timescale 1ns/1ps
package fault_irq_pkg;

    localparam int MAX_SOURCES = 8;
    localparam int ADDR_W      = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_PENDING = 2'd0,
        SEL_ENABLE  = 2'd1,
        SEL_CAUSE   = 2'd2,
        SEL_RSVD    = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/fault_sync_chain.sv
`timescale 1ns/1ps
module fault_sync_chain #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    generate
        if (STAGES == 0) begin : g_bypass
            assign sync_out = async_in;
        end else begin : g_chain
            logic [WIDTH-1:0] stage_d [STAGES];
            logic [WIDTH-1:0] stage_q [STAGES];

            always_comb begin
                stage_d[0] = async_in;
                for (int s = 1; s < STAGES; s++) begin
                    stage_d[s] = stage_q[s-1];
                end
            end

            always_ff @(posedge clk) begin
                for (int s = 0; s < STAGES; s++) begin
                    if (!rst_n) begin
                        stage_q[s] <= '0;
                    end else begin
                        stage_q[s] <= stage_d[s];
                    end
                end
            end

            assign sync_out = stage_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/fault_capture.sv
`timescale 1ns/1ps
module fault_capture #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] level_now,
    input  logic [WIDTH-1:0] level_prev_q,
    input  logic [WIDTH-1:0] pending_q,
    input  logic [WIDTH-1:0] clear_vec,
    output logic [WIDTH-1:0] rise_vec,
    output logic [WIDTH-1:0] pending_nxt
);

    always_comb begin
        for (int i = 0; i < WIDTH; i++) begin
            rise_vec[i] = level_now[i] & ~level_prev_q[i];
            // A fresh edge outranks an acknowledgement in the same cycle.
            if (rise_vec[i]) begin
                pending_nxt[i] = 1'b1;
            end else if (clear_vec[i]) begin
                pending_nxt[i] = 1'b0;
            end else begin
                pending_nxt[i] = pending_q[i];
            end
        end
    end

endmodule

// File: rtl/irq_reg_decode.sv
`timescale 1ns/1ps
module irq_reg_decode
    import fault_irq_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WIDTH-1:0]  wdata,
    input  logic [WIDTH-1:0]  pending_q,
    input  logic [WIDTH-1:0]  enable_q,
    output logic [WIDTH-1:0]  clear_vec,
    output logic              enable_we,
    output logic [WIDTH-1:0]  rdata
);

    reg_sel_e sel;

    always_comb begin
        sel       = reg_sel_e'(addr);
        clear_vec = '0;
        enable_we = 1'b0;
        rdata     = '0;
        unique case (sel)
            SEL_PENDING: begin
                rdata = pending_q;
                if (wr_en) clear_vec = wdata;
            end
            SEL_ENABLE: begin
                rdata     = enable_q;
                enable_we = wr_en;
            end
            SEL_CAUSE: begin
                rdata = pending_q & enable_q;
            end
            SEL_RSVD: begin
                rdata = '0;
            end
            default: begin
                rdata = '0;
            end
        endcase
    end

endmodule

// File: rtl/fault_irq_hub.sv
`timescale 1ns/1ps
module fault_irq_hub
    import fault_irq_pkg::*;
#(
    parameter int NUM_SRC     = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] fault_in,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [NUM_SRC-1:0] bus_wdata,
    output logic [NUM_SRC-1:0] bus_rdata,
    output logic               irq_out
);

    localparam int SRC_W = (NUM_SRC > MAX_SOURCES) ? MAX_SOURCES : NUM_SRC;

    typedef struct packed {
        logic [SRC_W-1:0] level_prev;
        logic [SRC_W-1:0] pending;
        logic [SRC_W-1:0] enable;
        logic             irq;
    } hub_state_t;

    hub_state_t state_d, state_q;

    logic [SRC_W-1:0] level_sync;
    logic [SRC_W-1:0] rise_vec;
    logic [SRC_W-1:0] pending_nxt;
    logic [SRC_W-1:0] clear_vec;
    logic             enable_we;
    logic [SRC_W-1:0] rdata_int;
    logic [SRC_W-1:0] pending_q;
    logic [SRC_W-1:0] enable_q;

    assign pending_q = state_q.pending;
    assign enable_q  = state_q.enable;

    fault_sync_chain #(
        .WIDTH (SRC_W),
        .STAGES(SYNC_STAGES)
    ) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_in(fault_in[SRC_W-1:0]),
        .sync_out(level_sync)
    );

    irq_reg_decode #(
        .WIDTH(SRC_W)
    ) decode_i (
        .wr_en    (bus_wr),
        .addr     (bus_addr),
        .wdata    (bus_wdata[SRC_W-1:0]),
        .pending_q(state_q.pending),
        .enable_q (state_q.enable),
        .clear_vec(clear_vec),
        .enable_we(enable_we),
        .rdata    (rdata_int)
    );

    fault_capture #(
        .WIDTH(SRC_W)
    ) capture_i (
        .level_now   (level_sync),
        .level_prev_q(state_q.level_prev),
        .pending_q   (state_q.pending),
        .clear_vec   (clear_vec),
        .rise_vec    (rise_vec),
        .pending_nxt (pending_nxt)
    );

    always_comb begin
        state_d            = state_q;
        state_d.level_prev = level_sync;
        state_d.pending    = pending_nxt;
        if (enable_we) begin
            state_d.enable = bus_wdata[SRC_W-1:0];
        end
        state_d.irq = |(state_d.pending & state_d.enable);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    generate
        if (SRC_W < NUM_SRC) begin : g_pad
            assign bus_rdata = {{(NUM_SRC-SRC_W){1'b0}}, rdata_int};
        end else begin : g_full
            assign bus_rdata = rdata_int;
        end
    endgenerate

    assign irq_out = state_q.irq;

endmodule

// File: rtl/fault_irq_hub_chk.sv
`timescale 1ns/1ps
module fault_irq_hub_chk
    import fault_irq_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int SRC_W   = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_wr,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [NUM_SRC-1:0] bus_wdata,
    input logic [NUM_SRC-1:0] bus_rdata,
    input logic               irq_out,
    input logic [SRC_W-1:0]   pending_q,
    input logic [SRC_W-1:0]   enable_q,
    input logic [SRC_W-1:0]   rise_vec
);

    logic wr_pending;
    logic wr_enable;
    assign wr_pending = bus_wr && (bus_addr == SEL_PENDING);
    assign wr_enable  = bus_wr && (bus_addr == SEL_ENABLE);

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (pending_q == '0 && enable_q == '0 && irq_out == 1'b0));

    assert_sticky_pending_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_pending |=> ((pending_q & $past(pending_q)) == $past(pending_q)));

    assert_edge_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_vec != '0) |=> ((pending_q & $past(rise_vec)) == $past(rise_vec)));

    assert_clear_ones_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pending && rise_vec == '0) |=> ((pending_q & $past(bus_wdata[SRC_W-1:0])) == '0));

    assert_edge_beats_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pending && ((bus_wdata[SRC_W-1:0] & rise_vec) != '0))
        |=> ((pending_q & $past(bus_wdata[SRC_W-1:0] & rise_vec)) == $past(bus_wdata[SRC_W-1:0] & rise_vec)));

    assert_enable_store_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_enable |=> (enable_q == $past(bus_wdata[SRC_W-1:0])));

    assert_irq_matches_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out == (|(pending_q & enable_q)));

    assert_cause_view_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == SEL_CAUSE) |-> (bus_rdata[SRC_W-1:0] == (pending_q & enable_q)));

    assert_rsvd_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == SEL_RSVD) |-> (bus_rdata == '0));

endmodule

bind fault_irq_hub fault_irq_hub_chk #(
    .NUM_SRC(NUM_SRC),
    .SRC_W  (SRC_W)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .irq_out  (irq_out),
    .pending_q(pending_q),
    .enable_q (enable_q),
    .rise_vec (rise_vec)
);

// File: tb/fault_irq_hub_tb.sv
`timescale 1ns/1ps
module fault_irq_hub_tb_top;

    localparam int N    = 8;
    localparam int SYNC = 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] fault_in = '0;
    logic         bus_wr = 1'b0;
    logic [1:0]   bus_addr = 2'd0;
    logic [N-1:0] bus_wdata = '0;
    logic [N-1:0] bus_rdata;
    logic         irq_out;

    int checks   = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    fault_irq_hub #(
        .NUM_SRC    (N),
        .SYNC_STAGES(SYNC)
    ) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .fault_in (fault_in),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .irq_out  (irq_out)
    );

    // Behavioural reference model
    logic [N-1:0] m_prev, m_pend, m_mask, m_seen, m_rise, m_clr;
    logic         m_irq;
    logic [N-1:0] hist[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_prev = '0; m_pend = '0; m_mask = '0; m_irq = 1'b0;
            hist = {};
            for (int k = 0; k < SYNC; k++) hist.push_back('0);
        end else begin
            m_seen = (SYNC == 0) ? fault_in : hist[SYNC-1];
            m_rise = m_seen & ~m_prev;
            m_clr  = (bus_wr && bus_addr == 2'd0) ? bus_wdata : '0;
            if (bus_wr && bus_addr == 2'd1) m_mask = bus_wdata;
            m_pend = (m_pend & ~m_clr) | m_rise;
            m_prev = m_seen;
            m_irq  = |(m_pend & m_mask);
            if (SYNC > 0) begin
                hist.push_front(fault_in);
                void'(hist.pop_back());
            end
        end
    end

    function automatic logic [N-1:0] model_read(input logic [1:0] a);
        case (a)
            2'd0:    return m_pend;
            2'd1:    return m_mask;
            2'd2:    return m_pend & m_mask;
            default: return '0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check("R7 irq_out vs model", {{(N-1){1'b0}}, irq_out}, {{(N-1){1'b0}}, m_irq});
            case (bus_addr)
                2'd0:    check("R2 pending view vs model", bus_rdata, model_read(bus_addr));
                2'd1:    check("R6 enable view vs model", bus_rdata, model_read(bus_addr));
                default: check("R8 cause/reserved view vs model", bus_rdata, model_read(bus_addr));
            endcase
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic idle();
        bus_wr = 1'b0;
    endtask

    task automatic write_reg(input logic [1:0] a, input logic [N-1:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        step();
        bus_wr = 1'b0;
    endtask

    task automatic read_check(input logic [1:0] a, input logic [N-1:0] exp, input string tag);
        bus_addr = a;
        #0.5;
        check(tag, bus_rdata, exp);
    endtask

    task automatic irq_check(input logic exp, input string tag);
        check(tag, {{(N-1){1'b0}}, irq_out}, {{(N-1){1'b0}}, exp});
    endtask

    initial begin
        #400000;
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        // R1: reset state
        read_check(2'd0, '0, "R1 pending in reset");
        irq_check(1'b0, "R1 irq in reset");
        rst_n = 1'b1;
        step();
        read_check(2'd0, '0, "R1 pending after reset");
        read_check(2'd1, '0, "R1 enable after reset");
        irq_check(1'b0, "R1 irq after reset");

        // R6: enable register write/read
        write_reg(2'd1, 8'hA5);
        read_check(2'd1, 8'hA5, "R6 enable readback");
        write_reg(2'd1, 8'hFF);
        read_check(2'd1, 8'hFF, "R6 enable readback all");

        // R9 + R2: one-cycle pulse, latency SYNC+1 edges
        fault_in[3] = 1'b1;
        step();
        fault_in[3] = 1'b0;
        for (int k = 1; k < SYNC; k++) step();
        read_check(2'd0, 8'h00, "R9 not yet captured");
        step();
        read_check(2'd0, 8'h08, "R9 captured after sync depth");
        irq_check(1'b1, "R7 irq raised by enabled source");
        repeat (4) step();
        read_check(2'd0, 8'h08, "R2 pending stays set");

        // R4: write zeros keeps, ones clear
        write_reg(2'd0, 8'h00);
        read_check(2'd0, 8'h08, "R4 zero write leaves bit");
        write_reg(2'd0, 8'h08);
        read_check(2'd0, 8'h00, "R4 one write clears bit");
        irq_check(1'b0, "R7 irq drops with clear");

        // R3: level held high captured once
        fault_in[5] = 1'b1;
        repeat (SYNC + 2) step();
        read_check(2'd0, 8'h20, "R3 held level sets bit");
        write_reg(2'd0, 8'h20);
        repeat (SYNC + 3) step();
        read_check(2'd0, 8'h00, "R3 held level does not re-set");
        fault_in[5] = 1'b0;
        repeat (SYNC + 2) step();
        fault_in[5] = 1'b1;
        repeat (SYNC + 2) step();
        read_check(2'd0, 8'h20, "R3 new edge sets again");
        fault_in[5] = 1'b0;
        write_reg(2'd0, 8'hFF);

        // R7/R8: masked source
        write_reg(2'd1, 8'h01);
        fault_in[2] = 1'b1; fault_in[6] = 1'b1;
        step();
        fault_in = '0;
        repeat (SYNC + 2) step();
        read_check(2'd0, 8'h44, "R2 two sources pending");
        irq_check(1'b0, "R7 irq off when sources masked");
        read_check(2'd2, 8'h00, "R8 cause empty when masked");
        write_reg(2'd1, 8'h04);
        irq_check(1'b1, "R7 irq on when enabled");
        read_check(2'd2, 8'h04, "R8 cause shows enabled source");
        read_check(2'd3, 8'h00, "R8 reserved reads zero");

        // R8: writes to cause/reserved change nothing
        write_reg(2'd2, 8'hFF);
        write_reg(2'd3, 8'hFF);
        read_check(2'd0, 8'h44, "R8 pending untouched by cause write");
        read_check(2'd1, 8'h04, "R8 enable untouched by reserved write");
        write_reg(2'd0, 8'hFF);

        // R5: clear and new edge in the same cycle
        write_reg(2'd1, 8'hFF);
        fault_in[1] = 1'b1;
        repeat (SYNC) step();
        bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = 8'h02;
        step();
        idle();
        read_check(2'd0, 8'h02, "R5 edge wins over clear");
        irq_check(1'b1, "R5 irq stays up");
        fault_in[1] = 1'b0;
        write_reg(2'd0, 8'hFF);

        // Random traffic against the model
        for (int c = 0; c < 2000; c++) begin
            if (($urandom % 4) == 0) fault_in = N'($urandom);
            bus_wr    = (($urandom % 5) == 0);
            bus_addr  = 2'($urandom);
            bus_wdata = N'($urandom);
            step();
        end
        idle();
        step();

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule